// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends a command frame from a reader to a card by gating a single carrier-enable line. Each data bit becomes a short, fixed-length gap in the carrier, followed by a stretch of carrier whose length carries the bit value. Before it is encoded, every data bit is scrambled with one bit from an external keystream source. The block asks that source to step once per bit.

A frame starts on a one-cycle start strobe that carries a data word and a bit count. Bits go out least significant first. After the last data bit the block emits one more gap, which marks the end of the frame. It then raises the carrier again and pulses done.

All timing is counted in ticks of the system clock divided by a fixed prescaler. The block owns that prescaler. At frame end it restarts the prescaler and a tick counter, so that a following receive window can be timed from the exact end of the transmission.

Top module: `pp_frame_tx`

## Requirements
- R1: Out of reset and between frames, carrier is 1, and busy, done and ks_adv are 0.
- R2: A start seen while idle makes carrier drop at the next clock edge. Every bit begins with carrier low for PAUSE_TICKS*TICK_DIV cycles.
- R3: The whole bit period, measured from the start of its gap, is ONE_TICKS*TICK_DIV cycles for an encoded 1 and ZERO_TICKS*TICK_DIV cycles for an encoded 0. Carrier is high for the part of the period after the gap.
- R4: The encoded value of bit i is data[i] XOR ks_bit. Bit 0 (least significant) is sent first. ks_bit is sampled at the clock edge that ends that bit's gap.
- R5: ks_adv pulses for one cycle once per transmitted bit, so a frame of n bits steps the keystream exactly n times. ks_adv is never high while idle.
- R6: After the last bit, carrier stays low for one more PAUSE_TICKS*TICK_DIV cycles and then returns high. In that same cycle done is 1 for exactly one cycle and busy falls.
- R7: A bit count of 0 sends only the closing gap and requests no keystream step.
- R8: A bit count above MAX_BITS is treated as MAX_BITS.
- R9: A start strobe that arrives while busy is ignored, and the frame in flight continues unchanged.
- R10: gap is 0 while busy and is cleared at frame end. After that it rises by one every TICK_DIV cycles and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| data | input | MAX_BITS | Frame payload, LSB sent first |
| nbits | input | $clog2(MAX_BITS+1) | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Keystream step request, one per bit |
| carrier | output | 1 | Carrier enable (1 = on) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of the closing gap |
| gap | output | GAP_W | Ticks elapsed since the last frame end, saturating |

## Verification
The hardest situation to reach is a start request that lands in the middle of a frame. An ignored request leaves no trace of its own, so it is visible only because the waveform carries on exactly as predicted. The stimulus issues a second start with different data partway through a frame. A cycle-accurate model predicts the carrier in every cycle from data XOR keystream, so any disturbance to the frame in flight shows up at once. Clamped bit counts, the empty frame and gap saturation are each reached by dedicated frames, with long idle stretches between them.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_MARK  = 2'd2,
    ST_CLOSE = 2'd3
  } ppt_state_e;
endpackage

// File: rtl/ppt_tick_gen.sv
module ppt_tick_gen #(
  parameter int TICK_DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/ppt_gap_timer.sv
module ppt_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  output logic [GAP_W-1:0] gap
);
  always_ff @(posedge clk) begin
    if (rst || clr) gap <= '0;
    else if (en && tick && (gap != {GAP_W{1'b1}})) gap <= gap + 1'b1;
  end
endmodule

// File: rtl/ppt_frame_fsm.sv
module ppt_frame_fsm
  import ppt_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  localparam int NW   = $clog2(MAX_BITS + 1),
  localparam int LONG = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS,
  localparam int TW   = $clog2(LONG + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                start,
  input  logic [MAX_BITS-1:0] data,
  input  logic [NW-1:0]       nbits,
  input  logic                ks_bit,
  output logic                ks_adv,
  output logic                carrier,
  output logic                busy,
  output logic                done,
  output logic                tmr_clr
);
  localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_TICKS - 1);
  localparam logic [TW-1:0] ONE_LAST   = TW'(ONE_TICKS - 1);
  localparam logic [TW-1:0] ZERO_LAST  = TW'(ZERO_TICKS - 1);

  ppt_state_e          state;
  logic [MAX_BITS-1:0] sh;
  logic [NW-1:0]       left;
  logic [TW-1:0]       tcnt;
  logic                enc;

  logic          accept, pause_end, mark_end, close_end;
  logic [TW-1:0] mark_last;
  logic [NW-1:0] n_eff;

  always_comb begin
    n_eff     = (nbits > NW'(MAX_BITS)) ? NW'(MAX_BITS) : nbits;
    mark_last = enc ? ONE_LAST : ZERO_LAST;
    accept    = (state == ST_IDLE) && start;
    pause_end = (state == ST_PAUSE) && tick && (tcnt == PAUSE_LAST);
    mark_end  = (state == ST_MARK) && tick && (tcnt == mark_last);
    close_end = (state == ST_CLOSE) && tick && (tcnt == PAUSE_LAST);
    tmr_clr   = accept || close_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sh      <= '0;
      left    <= '0;
      tcnt    <= '0;
      enc     <= 1'b0;
      carrier <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      ks_adv  <= 1'b0;
    end else begin
      done   <= 1'b0;
      ks_adv <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            sh      <= data;
            left    <= n_eff;
            tcnt    <= '0;
            carrier <= 1'b0;
            busy    <= 1'b1;
            state   <= (n_eff == '0) ? ST_CLOSE : ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (pause_end) begin
            carrier <= 1'b1;
            enc     <= sh[0] ^ ks_bit;
            ks_adv  <= 1'b1;
            state   <= ST_MARK;
          end
        end
        ST_MARK: begin
          if (mark_end) begin
            tcnt    <= '0;
            carrier <= 1'b0;
            sh      <= sh >> 1;
            left    <= left - 1'b1;
            state   <= (left == NW'(1)) ? ST_CLOSE : ST_PAUSE;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_CLOSE: begin
          if (close_end) begin
            tcnt    <= '0;
            carrier <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_frame_tx.sv
module pp_frame_tx #(
  parameter int TICK_DIV    = 32,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int MAX_BITS    = 32,
  parameter int GAP_W       = 16,
  localparam int NW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MAX_BITS-1:0] data,
  input  logic [NW-1:0]       nbits,
  input  logic                ks_bit,
  output logic                ks_adv,
  output logic                carrier,
  output logic                busy,
  output logic                done,
  output logic [GAP_W-1:0]    gap
);
  logic tick, tmr_clr;

  ppt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick)
  );

  ppt_frame_fsm #(
    .MAX_BITS(MAX_BITS), .PAUSE_TICKS(PAUSE_TICKS),
    .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .data(data),
    .nbits(nbits), .ks_bit(ks_bit), .ks_adv(ks_adv), .carrier(carrier),
    .busy(busy), .done(done), .tmr_clr(tmr_clr)
  );

  ppt_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(!busy), .tick(tick), .gap(gap)
  );
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker #(
  parameter int GAP_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             carrier,
  input logic             busy,
  input logic             done,
  input logic             ks_adv,
  input logic [GAP_W-1:0] gap
);
  assert_idle_carrier_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> carrier);
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
  assert_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier) |-> (ks_adv || done));
  assert_adv_busy_R5: assert property (@(posedge clk) disable iff (rst)
    ks_adv |-> busy);
  assert_adv_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    ks_adv |=> !ks_adv);
  assert_done_end_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (carrier && !busy));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_gap_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (gap == '0));
endmodule

bind pp_frame_tx ppt_checker #(.GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .carrier(carrier), .busy(busy),
  .done(done), .ks_adv(ks_adv), .gap(gap)
);

// File: tb/tb_pp_frame_tx.sv
module tb_pp_frame_tx;
  localparam int DIV = 2, PAUSE = 3, ONE = 10, ZERO = 6, MAXB = 32, GW = 4;
  localparam int NW = $clog2(MAXB + 1);
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 0, rst = 1, start = 0, ks_bit;
  logic [MAXB-1:0] data = '0;
  logic [NW-1:0] nbits = '0;
  logic ks_adv, carrier, busy, done;
  logic [GW-1:0] gap;

  always #5 clk = ~clk;

  pp_frame_tx #(.TICK_DIV(DIV), .PAUSE_TICKS(PAUSE), .ONE_TICKS(ONE),
    .ZERO_TICKS(ZERO), .MAX_BITS(MAXB), .GAP_W(GW)) dut (
    .clk(clk), .rst(rst), .start(start), .data(data), .nbits(nbits),
    .ks_bit(ks_bit), .ks_adv(ks_adv), .carrier(carrier), .busy(busy),
    .done(done), .gap(gap));

  int total = 0, bad = 0, cyc = 0;
  int ks_idx = 0, cur_base = 0, cur_n = 0, gap_cyc = -1;
  bit q[$];
  bit checking = 0, prev_eb = 0;

  function automatic logic ks_of(int i);
    return ((i * 13 + i / 3) % 5) < 2;
  endfunction
  assign ks_bit = ks_of(ks_idx);

  always @(posedge clk) if (!rst && ks_adv) ks_idx <= ks_idx + 1;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    bit eb, ec, ed;
    cyc++;
    if (checking) begin
      if (q.size() > 0) begin ec = q.pop_front(); eb = 1; end
      else begin ec = 1; eb = 0; end
      ed = prev_eb && !eb;
      chk("R2/R3/R4 carrier", int'(carrier), int'(ec));
      chk("R6 busy", int'(busy), int'(eb));
      chk("R6 done", int'(done), int'(ed));
      if (!eb) chk("R5 ks_adv idle", int'(ks_adv), 0);
      if (ed) begin
        chk("R5 keystream steps", ks_idx - cur_base, cur_n);
        gap_cyc = 0;
      end
      if (eb) chk("R10 gap busy", int'(gap), 0);
      else if (gap_cyc >= 0) begin
        chk("R10 gap count", int'(gap), (gap_cyc / DIV > GMAX) ? GMAX : gap_cyc / DIV);
        gap_cyc++;
      end
      prev_eb = eb;
    end
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(logic [31:0] d, int n);
    @(negedge clk); #1;
    start = 1; data = d; nbits = NW'(n);
    if (!prev_eb) begin
      int ne;
      ne = (n > MAXB) ? MAXB : n;
      cur_base = ks_idx; cur_n = ne; gap_cyc = -1;
      for (int i = 0; i < ne; i++) begin
        bit b;
        b = d[i] ^ ks_of(ks_idx + i);
        for (int c = 0; c < PAUSE * DIV; c++) q.push_back(1'b0);
        for (int c = 0; c < ((b ? ONE : ZERO) - PAUSE) * DIV; c++) q.push_back(1'b1);
      end
      for (int c = 0; c < PAUSE * DIV; c++) q.push_back(1'b0);
    end
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic wait_idle(int extra);
    while (q.size() > 0) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset carrier", int'(carrier), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset ks_adv", int'(ks_adv), 0);
    #1 rst = 0; checking = 1;
    send(32'h0, 0);               wait_idle(5);   // R7 empty frame
    send(32'h1, 1);               wait_idle(5);
    send(32'hA5, 8);              wait_idle(3);
    send(32'hFFFF_FFFF, 32);      wait_idle(4);
    send(32'h0, 32);              wait_idle(2);
    send(32'h1234_5678, 40);      wait_idle(6);   // R8 clamp
    send(32'h0000_0C3A, 12);                      // R9 ignored restart
    repeat (25) @(negedge clk);
    send(32'hFFFF_0000, 20);
    wait_idle(45);                                // R10 saturation
    send(32'h5, 3);               wait_idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule